// File: doc/BRIEF.md
# Serial Port FIFO Control with Level Interrupts

This block holds the transmit and receive queues of a serial port together with the control register that governs them. Software writes one byte to configure the block. That byte turns the queues on, selects the occupancy levels that raise the receive and transmit interrupts, and can request a one-cycle reset of either data path. The control register cannot be read at its write address. Its live value is available on a separate shadow output. The bits that request resets always read back as zero there.

The surrounding serial engine pushes received characters into the receive queue and pops characters from the transmit queue. The host side does the reverse. Each queue reports its occupancy, full and empty. Queue depth is a build parameter, either 16 or 32, and each interrupt threshold code decodes through a table chosen by that depth. When the queues are switched off, each path shrinks to a single holding register. An infrared mode input forces both queues on, whatever the enable bit says. An extended mode input decides whether the transmit threshold is used at all.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the shadow value is 00h, both queues are empty, no soft-reset pulse is active, `rx_irq` is 0 and `tx_irq` is 1.
- R2: A write to the control port stores bits 7:4 and bit 0 of the written byte. On `cfg_shadow`, bits 7:4 and bit 0 show the stored value and bits 3:1 always read 0.
- R3: With the queues enabled (shadow bit 0 = 1, or `mode_ir` = 1), each queue holds DEPTH entries in first-in first-out order. A push into a full queue is dropped, unless a pop in the same cycle frees space first. A push and a pop in the same cycle on a queue that is not full leave the level unchanged.
- R4: With the queues disabled (shadow bit 0 = 0 and `mode_ir` = 0), each queue holds at most one entry, and a push while it is occupied is dropped.
- R5: Receive threshold code = shadow bits 7:6. Codes 00/01/10/11 give levels 1/4/8/14 at DEPTH 16 and 1/8/16/26 at DEPTH 32. While enabled, `rx_irq` = (rx_level >= level). While disabled, `rx_irq` = (rx_level != 0).
- R6: With `mode_ext` = 1, the transmit threshold code is shadow bits 5:4. Codes 00/01/10/11 give levels 1/3/9/13 at DEPTH 16 and 1/7/17/25 at DEPTH 32. `tx_irq` = (tx_level < level).
- R7: With `mode_ext` = 0, the transmit threshold field has no effect and `tx_irq` = (tx_level == 0).
- R8: Writing a byte with bit 2 set drives `tx_soft_rst` high for exactly the next cycle. At the end of that cycle the transmit queue is emptied, and any push in that cycle is dropped. The receive queue is not affected.
- R9: Writing a byte with bit 1 set drives `rx_soft_rst` high for exactly the next cycle. At the end of that cycle the receive queue is emptied, and any push in that cycle is dropped. The transmit queue is not affected.
- R10: A write that clears bit 0 while shadow bit 0 is 1 and `mode_ir` is 0 empties both queues at the edge of that write.
- R11: With `mode_ir` = 1, both queues act as enabled at full depth whatever the value of bit 0. Clearing bit 0 in this mode does not empty them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_shadow | output | 8 | Shadow read-back of the control register |
| mode_ext | input | 1 | Extended mode: enables the transmit threshold |
| mode_ir | input | 1 | Infrared mode: forces both queues on |
| tx_push | input | 1 | Host writes a character to the transmit queue |
| tx_push_data | input | DATA_W | Character to transmit |
| tx_pop | input | 1 | Transmitter takes the head character |
| tx_pop_data | output | DATA_W | Head of the transmit queue |
| tx_level | output | $clog2(DEPTH)+1 | Transmit queue occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Receiver stores a character |
| rx_push_data | input | DATA_W | Received character |
| rx_pop | input | 1 | Host takes the head character |
| rx_pop_data | output | DATA_W | Head of the receive queue |
| rx_level | output | $clog2(DEPTH)+1 | Receive queue occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |
| tx_soft_rst | output | 1 | One-cycle reset pulse to the transmitter |
| rx_soft_rst | output | 1 | One-cycle reset pulse to the receiver |

## Verification
The embedded assertions check several rules on every cycle. Occupancy never exceeds the depth, and a push into a full queue never changes its level. A reset pulse always follows a write that requested it, and the queue it targets is always empty one cycle later. Disabling the queues always empties both. An empty receive queue never raises its interrupt, and an empty transmit queue always raises its interrupt. Other behaviour depends on sequences of stimulus, so only the bench scenarios show it. This covers first-in first-out ordering, each threshold code crossing at its decoded level, the single-entry disabled mode, the infrared override and the isolation of one path's reset from the other. A behavioural model checks these on every clock.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_shadow,
  input  logic              mode_ext,
  input  logic              mode_ir,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_pop_data,
  output logic [LW-1:0]     tx_level,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_pop_data,
  output logic [LW-1:0]     rx_level,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              tx_soft_rst,
  output logic              rx_soft_rst
);

  logic [3:0] thr_q;
  logic       en_q;

  assign cfg_shadow = {thr_q, 3'b000, en_q};

  wire          q_on   = en_q | mode_ir;
  wire          drop   = cfg_we & en_q & ~cfg_wdata[0] & ~mode_ir;
  wire [LW-1:0] room   = q_on ? LW'(DEPTH) : LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q       <= '0;
      en_q        <= 1'b0;
      tx_soft_rst <= 1'b0;
      rx_soft_rst <= 1'b0;
    end else begin
      tx_soft_rst <= cfg_we & cfg_wdata[2];
      rx_soft_rst <= cfg_we & cfg_wdata[1];
      if (cfg_we) begin
        thr_q <= cfg_wdata[7:4];
        en_q  <= cfg_wdata[0];
      end
    end
  end

  logic [1:0]        q_push, q_pop, q_clr;
  logic [DATA_W-1:0] q_din  [2];
  logic [DATA_W-1:0] q_dout [2];
  logic [LW-1:0]     q_cnt  [2];

  assign q_push = {rx_push, tx_push};
  assign q_pop  = {rx_pop, tx_pop};
  assign q_clr  = {rx_soft_rst | drop, tx_soft_rst | drop};
  assign q_din[0] = tx_push_data;
  assign q_din[1] = rx_push_data;

  for (genvar g = 0; g < 2; g++) begin : g_q
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [LW-1:0]     cnt;
    wire               is_full = cnt >= room;
    wire               take    = q_pop[g] & (cnt != '0);
    wire               put     = q_push[g] & (~is_full | take);

    always_ff @(posedge clk) begin
      if (put && !q_clr[g]) mem[wp] <= q_din[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else if (q_clr[g]) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (put)  wp <= wp + 1'b1;
        if (take) rp <= rp + 1'b1;
        cnt <= cnt + LW'(put) - LW'(take);
      end
    end

    assign q_dout[g] = mem[rp];
    assign q_cnt[g]  = cnt;
  end

  assign tx_pop_data = q_dout[0];
  assign rx_pop_data = q_dout[1];
  assign tx_level    = q_cnt[0];
  assign rx_level    = q_cnt[1];
  assign tx_full     = tx_level >= room;
  assign rx_full     = rx_level >= room;
  assign tx_empty    = tx_level == '0;
  assign rx_empty    = rx_level == '0;

  function automatic logic [LW-1:0] rx_mark(input logic [1:0] c);
    case (c)
      2'd0:    return LW'(1);
      2'd1:    return (DEPTH == 32) ? LW'(8)  : LW'(4);
      2'd2:    return (DEPTH == 32) ? LW'(16) : LW'(8);
      default: return (DEPTH == 32) ? LW'(26) : LW'(14);
    endcase
  endfunction

  function automatic logic [LW-1:0] tx_mark(input logic [1:0] c);
    case (c)
      2'd0:    return LW'(1);
      2'd1:    return (DEPTH == 32) ? LW'(7)  : LW'(3);
      2'd2:    return (DEPTH == 32) ? LW'(17) : LW'(9);
      default: return (DEPTH == 32) ? LW'(25) : LW'(13);
    endcase
  endfunction

  assign rx_irq = q_on ? (rx_level >= rx_mark(thr_q[3:2])) : !rx_empty;
  assign tx_irq = mode_ext ? (tx_level < tx_mark(thr_q[1:0])) : tx_empty;

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_push && !tx_pop && !tx_soft_rst && !cfg_we |=> $stable(tx_level));

  assert_tx_pulse_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soft_rst |-> $past(cfg_we && cfg_wdata[2]));

  assert_tx_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soft_rst |=> tx_level == '0);

  assert_rx_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soft_rst |=> rx_level == '0);

  assert_disable_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_shadow[0] && !cfg_wdata[0] && !mode_ir |=> tx_level == '0 && rx_level == '0);

  assert_rx_irq_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_irq);

  assert_tx_irq_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_irq);

endmodule

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_wdata = 0; logic [7:0] cfg_shadow;
  logic mode_ext = 0, mode_ir = 0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_push_data = 0, rx_push_data = 0, tx_pop_data, rx_pop_data;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_irq, tx_irq, tx_soft_rst, rx_soft_rst;

  uart_fifo_ctl #(.DEPTH(DEPTH), .DATA_W(8)) u_uart_fifo_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur = "R1";
  logic [7:0] txq[$], rxq[$];
  logic [7:0] m_sh = 0;
  logic m_txp = 0, m_rxp = 0;
  int rx_tab[4] = '{1, 4, 8, 14};
  int tx_tab[4] = '{1, 3, 9, 13};

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); m_sh = 0; m_txp = 0; m_rxp = 0;
    end else begin
      int cap;
      bit fl, tpo, tpu, rpo, rpu;
      cap = (m_sh[0] || mode_ir) ? DEPTH : 1;
      fl  = cfg_we && m_sh[0] && !cfg_wdata[0] && !mode_ir;
      tpo = tx_pop && txq.size() > 0;
      tpu = tx_push && (txq.size() < cap || tpo);
      rpo = rx_pop && rxq.size() > 0;
      rpu = rx_push && (rxq.size() < cap || rpo);
      if (m_txp || fl) txq.delete();
      else begin
        if (tpo) void'(txq.pop_front());
        if (tpu) txq.push_back(tx_push_data);
      end
      if (m_rxp || fl) rxq.delete();
      else begin
        if (rpo) void'(rxq.pop_front());
        if (rpu) rxq.push_back(rx_push_data);
      end
      m_txp = cfg_we && cfg_wdata[2];
      m_rxp = cfg_we && cfg_wdata[1];
      if (cfg_we) m_sh = {cfg_wdata[7:4], 3'b000, cfg_wdata[0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int cap, el_rx, el_tx;
      cap = (m_sh[0] || mode_ir) ? DEPTH : 1;
      el_rx = (m_sh[0] || mode_ir) ? int'(rxq.size() >= rx_tab[m_sh[7:6]]) : int'(rxq.size() != 0);
      el_tx = mode_ext ? int'(txq.size() < tx_tab[m_sh[5:4]]) : int'(txq.size() == 0);
      chk(cfg_shadow == m_sh, "shadow", cfg_shadow, m_sh);
      chk(tx_level == txq.size(), "tx_level", tx_level, txq.size());
      chk(rx_level == rxq.size(), "rx_level", rx_level, rxq.size());
      chk(tx_full == (txq.size() >= cap) && tx_empty == (txq.size() == 0), "tx_flags", {tx_full, tx_empty}, 0);
      chk(rx_full == (rxq.size() >= cap) && rx_empty == (rxq.size() == 0), "rx_flags", {rx_full, rx_empty}, 0);
      chk(rx_irq == el_rx, "rx_irq", rx_irq, el_rx);
      chk(tx_irq == el_tx, "tx_irq", tx_irq, el_tx);
      chk(tx_soft_rst == m_txp, "tx_soft_rst", tx_soft_rst, m_txp);
      chk(rx_soft_rst == m_rxp, "rx_soft_rst", rx_soft_rst, m_rxp);
      if (txq.size() > 0) chk(tx_pop_data == txq[0], "tx_pop_data", tx_pop_data, txq[0]);
      if (rxq.size() > 0) chk(rx_pop_data == rxq[0], "rx_pop_data", rx_pop_data, rxq[0]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic nxt(); @(posedge clk); #2; endtask
  task automatic wr(input logic [7:0] d); cfg_we = 1; cfg_wdata = d; nxt(); cfg_we = 0; endtask
  task automatic tpush(input logic [7:0] d); tx_push = 1; tx_push_data = d; nxt(); tx_push = 0; endtask
  task automatic rpush(input logic [7:0] d); rx_push = 1; rx_push_data = d; nxt(); rx_push = 0; endtask
  task automatic tpop(); tx_pop = 1; nxt(); tx_pop = 0; endtask
  task automatic rpop(); rx_pop = 1; nxt(); rx_pop = 0; endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1; nxt();
    cur = "R1";
    chk(cfg_shadow == 8'h00 && tx_level == 0 && rx_level == 0 && !rx_irq && tx_irq, "reset", cfg_shadow, 0);

    cur = "R2"; wr(8'hBF); nxt();
    chk(cfg_shadow == 8'hB1, "shadow_bits", cfg_shadow, 8'hB1);
    wr(8'h4E); nxt();

    cur = "R3"; wr(8'h01);
    for (int i = 0; i < DEPTH + 2; i++) tpush(8'(i + 8'h40));
    chk(tx_level == DEPTH && tx_full, "tx_full_depth", tx_level, DEPTH);
    tx_push = 1; tx_pop = 1; tx_push_data = 8'hEE; nxt(); tx_push = 0; tx_pop = 0;
    for (int i = 0; i < DEPTH + 1; i++) tpop();
    rx_push = 1; rx_push_data = 8'h11; nxt();
    rx_pop = 1; rx_push_data = 8'h22; nxt(); rx_push = 0; rx_pop = 0; rpop();

    cur = "R5";
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 6) | 8'h01);
      for (int i = 0; i < DEPTH; i++) rpush(8'(c * 16 + i));
      wr(8'(c << 6) | 8'h03); nxt();
    end

    cur = "R6"; mode_ext = 1;
    for (int c = 0; c < 4; c++) begin
      wr(8'(c << 4) | 8'h01);
      for (int i = 0; i < DEPTH; i++) tpush(8'(i));
      for (int i = 0; i < DEPTH; i++) tpop();
    end

    cur = "R7"; mode_ext = 0; wr(8'h31);
    for (int i = 0; i < 3; i++) tpush(8'(i + 1));
    for (int i = 0; i < 3; i++) tpop();

    cur = "R8";
    for (int i = 0; i < 4; i++) begin tpush(8'(i)); rpush(8'(i + 9)); end
    cfg_we = 1; cfg_wdata = 8'h05; nxt(); cfg_we = 0;
    tx_push = 1; tx_push_data = 8'h77; nxt(); tx_push = 0; nxt();
    chk(tx_level == 0 && rx_level == 4, "tx_reset_only", tx_level, 0);

    cur = "R9";
    tpush(8'hA1); tpush(8'hA2);
    cfg_we = 1; cfg_wdata = 8'h03; nxt(); cfg_we = 0;
    rx_push = 1; rx_push_data = 8'h66; nxt(); rx_push = 0; nxt();
    chk(rx_level == 0 && tx_level == 2, "rx_reset_only", rx_level, 0);

    cur = "R10";
    rpush(8'h5A); rpush(8'h5B);
    wr(8'h00); nxt();
    chk(tx_level == 0 && rx_level == 0, "flush", tx_level + rx_level, 0);

    cur = "R4";
    rpush(8'h31); rpush(8'h32); tpush(8'h41); tpush(8'h42);
    chk(rx_level == 1 && rx_irq && rx_pop_data == 8'h31, "single_entry", rx_level, 1);
    rpop(); tpop(); wr(8'hC0); rpush(8'h33); rpop();

    cur = "R11"; mode_ir = 1;
    for (int i = 0; i < 5; i++) rpush(8'(i + 8'h70));
    chk(rx_level == 5, "ir_depth", rx_level, 5);
    wr(8'h01); wr(8'h00); nxt();
    chk(rx_level == 5, "ir_no_flush", rx_level, 5);
    for (int i = 0; i < 5; i++) rpop();
    mode_ir = 0; nxt();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule